// File: doc/BRIEF.md
# Framed Inter-Chip Message Link

This block is one endpoint of a 32-bit word-wide point-to-point link that carries framed messages between two switch devices. Its source side takes a message from local logic (a header of 2 to 4 words, then 0 to 64 payload words, marked with start and end flags). It drives the words onto the link with an enable signal that stays high for the whole message. It also inserts an idle cycle between messages. The source begins a message only while the far end grants XON, and it never cuts off a message it has started.

The target side watches the incoming enable and data. It stages each word for one cycle, so it can tell whether that word closed the message. It then writes the word into a receive FIFO with first, last and header tags. The header length comes from the low two bits of a message's first word. Local logic drains the FIFO through a show-ahead output. The target raises a flow-control line (1 = XOFF) when the FIFO has too little free space left to take a maximum-size message plus the words that may still be in flight. Both ends run on one clock. Message contents are otherwise not interpreted.

The source state machine has three states. TX_IDLE waits for a start word while XON holds; the transition launch_multi goes to TX_BODY, and launch_single goes straight to TX_GAP. TX_BODY sends one word per cycle until the end word, then takes the transition body_done to TX_GAP. TX_GAP holds one idle cycle and then takes gap_done back to TX_IDLE. The target state machine has two states. RX_IDLE waits for enable and takes capture_first to RX_HOLD. RX_HOLD pushes the staged word every cycle; it takes stay_hold while enable stays high and msg_close back to RX_IDLE when enable drops.

Top module: `msg_link`

## Requirements
- R1: After reset `lnk_tx_en` and `lnk_fc_out` are 0, `dst_valid` is 0 and `src_ready` is 1.
- R2: A word accepted on the local input (`src_valid` and `src_ready` high at a rising edge) appears on `lnk_tx_data` with `lnk_tx_en` high right after that edge, and words keep their order.
- R3: While a message is in progress, `src_ready` stays high, and `lnk_tx_en` stays high for every word from the start word to the end word.
- R4: In the cycle after the end word is accepted, `src_ready` is 0, and `lnk_tx_en` is 0 in the cycle after that, so at least one idle cycle separates messages.
- R5: A word offered while idle without `src_sop` is consumed and dropped: it never drives `lnk_tx_en` and never reaches the receive output.
- R6: `lnk_fc_in` high means XOFF. While XOFF is in effect, no new message starts and `src_ready` is 0 when idle. A message already in progress still completes without a stall.
- R7: Every word received with `lnk_rx_en` high is delivered once, in arrival order, on the `dst_*` outputs. `dst_valid` is high while the FIFO holds a word, and a word is removed at each rising edge where `dst_valid` and `dst_ready` are both high.
- R8: `dst_first` marks the first word received after `lnk_rx_en` rose. `dst_last` marks the word after which `lnk_rx_en` fell.
- R9: Bits [1:0] of a message's first word give its header length: 0 gives 2 words, 1 gives 3, and 2 or 3 give 4. `dst_hdr` is high on exactly those leading words, including the first word.
- R10: `lnk_fc_out` goes high when free FIFO entries drop below 71 (a 68-word maximum message plus 3 words in flight) and low when they are 71 or more. It follows the occupancy with one register stage. With the default depth of 128, it is low at 57 stored words and high at 58.
- R11: Under this flow control the receive FIFO is never written while it is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ends |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Local word offered |
| src_sop | input | 1 | Offered word starts a message |
| src_eop | input | 1 | Offered word ends a message |
| src_data | input | 32 | Offered word |
| src_ready | output | 1 | Offered word is taken at the next edge |
| lnk_tx_data | output | 32 | Link data toward the far end |
| lnk_tx_en | output | 1 | Link message envelope toward the far end |
| lnk_fc_in | input | 1 | Flow control from the far end, 1 = XOFF |
| lnk_rx_data | input | 32 | Link data from the far end |
| lnk_rx_en | input | 1 | Link message envelope from the far end |
| lnk_fc_out | output | 1 | Flow control toward the far end, 1 = XOFF |
| dst_valid | output | 1 | Receive FIFO holds a word |
| dst_data | output | 32 | Oldest received word |
| dst_first | output | 1 | Word opens a message |
| dst_last | output | 1 | Word closes a message |
| dst_hdr | output | 1 | Word belongs to the header |
| dst_ready | input | 1 | Local side removes the shown word |

## Verification
A word accepted at a rising edge is due on the link output one edge later. It reaches `dst_*` two edges after its acceptance, when the FIFO was empty. `lnk_fc_out` trails a change of occupancy by one edge, and `lnk_fc_in` blocks a start one edge after it rises. Stimulus is applied just after a rising edge and every result is sampled at the following falling edge. The link word is checked at the falling edge right after its acceptance edge, and the idle-cycle and ready checks fall on the next two falling edges. The flow-control checks wait six cycles after the last word so that the full pipeline has settled.

// File: rtl/msg_link_pkg.sv
package msg_link_pkg;

    parameter int PIPE_W = 32;
    parameter int IDX_W  = 3;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_BODY,
        TX_GAP
    } tx_state_t;

    typedef enum logic {
        RX_IDLE,
        RX_HOLD
    } rx_state_t;

    typedef struct packed {
        logic              hdr;
        logic              first;
        logic              last;
        logic [PIPE_W-1:0] data;
    } rx_word_t;

    // header word count from the two-bit code carried in the first word
    function automatic logic [IDX_W-1:0] hdr_words(input logic [1:0] code);
        logic [IDX_W-1:0] n;
        unique case (code)
            2'd0:    n = IDX_W'(2);
            2'd1:    n = IDX_W'(3);
            default: n = IDX_W'(4);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/msg_link_tx.sv
module msg_link_tx
    import msg_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_sop,
    input  logic              src_eop,
    input  logic [PIPE_W-1:0] src_data,
    output logic              src_ready,
    input  logic              fc_in,
    output logic [PIPE_W-1:0] tx_data,
    output logic              tx_en
);

    tx_state_t st_q, st_d;
    logic      xoff_q;
    logic      launch;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d      = st_q;
        src_ready = 1'b0;
        launch    = 1'b0;
        unique case (st_q)
            TX_IDLE: begin
                src_ready = !xoff_q;
                if (src_valid && !xoff_q && src_sop) begin
                    launch = 1'b1;
                    st_d   = src_eop ? TX_GAP : TX_BODY;   // launch_single / launch_multi
                end
            end
            TX_BODY: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    launch = 1'b1;
                    if (src_eop) begin
                        st_d = TX_GAP;                     // body_done
                    end
                end
            end
            TX_GAP: begin
                st_d = TX_IDLE;                            // gap_done
            end
            default: begin
                st_d = TX_IDLE;
            end
        endcase
    end

    // link drive registers and flow-control sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_q  <= 1'b0;
            tx_en   <= 1'b0;
            tx_data <= '0;
        end else begin
            xoff_q <= fc_in;
            tx_en  <= launch;
            if (launch) begin
                tx_data <= src_data;
            end
        end
    end

endmodule

// File: rtl/msg_link_rx.sv
module msg_link_rx
    import msg_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [PIPE_W-1:0] rx_data,
    output logic              push,
    output rx_word_t          push_word
);

    rx_state_t         st_q, st_d;
    logic [PIPE_W-1:0] hold_data;
    logic              hold_first;
    logic              hold_hdr;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  hdr_n_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        push = 1'b0;
        unique case (st_q)
            RX_IDLE: begin
                if (rx_en) begin
                    st_d = RX_HOLD;                        // capture_first
                end
            end
            RX_HOLD: begin
                push = 1'b1;
                st_d = rx_en ? RX_HOLD : RX_IDLE;          // stay_hold / msg_close
            end
            default: begin
                st_d = RX_IDLE;
            end
        endcase
    end

    assign push_word.data  = hold_data;
    assign push_word.first = hold_first;
    assign push_word.hdr   = hold_hdr;
    assign push_word.last  = !rx_en;

    // staging register: one word held until the next cycle shows the envelope
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_first <= 1'b0;
            hold_hdr   <= 1'b0;
            idx_q      <= '0;
            hdr_n_q    <= '0;
        end else if (rx_en) begin
            hold_data <= rx_data;
            if (st_q == RX_IDLE) begin
                hold_first <= 1'b1;
                hold_hdr   <= 1'b1;
                hdr_n_q    <= hdr_words(rx_data[1:0]);
                idx_q      <= IDX_W'(1);
            end else begin
                hold_first <= 1'b0;
                hold_hdr   <= (idx_q < hdr_n_q);
                idx_q      <= (idx_q == '1) ? idx_q : idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/msg_link_fifo.sv
module msg_link_fifo #(
    parameter int W          = 35,
    parameter int DEPTH      = 128,
    parameter int XOFF_LIMIT = 71
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         rd_en,
    output logic [W-1:0] rd_word,
    output logic         empty,
    output logic         full,
    output logic         xoff
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            xoff   <= 1'b0;
        end else begin
            xoff <= ((CW'(DEPTH) - count) < CW'(XOFF_LIMIT));
            if (do_wr) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (do_rd) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            if (do_wr && !do_rd) begin
                count <= count + CW'(1);
            end else if (do_rd && !do_wr) begin
                count <= count - CW'(1);
            end
        end
    end

endmodule

// File: rtl/msg_link.sv
module msg_link
    import msg_link_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int MAX_HDR    = 4,
    parameter int MAX_PAY    = 64,
    parameter int LINK_LAG   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic              src_sop,
    input  logic              src_eop,
    input  logic [PIPE_W-1:0] src_data,
    output logic              src_ready,
    output logic [PIPE_W-1:0] lnk_tx_data,
    output logic              lnk_tx_en,
    input  logic              lnk_fc_in,
    input  logic [PIPE_W-1:0] lnk_rx_data,
    input  logic              lnk_rx_en,
    output logic              lnk_fc_out,
    output logic              dst_valid,
    output logic [PIPE_W-1:0] dst_data,
    output logic              dst_first,
    output logic              dst_last,
    output logic              dst_hdr,
    input  logic              dst_ready
);

    localparam int MSG_MAX    = MAX_HDR + MAX_PAY;
    localparam int XOFF_LIMIT = MSG_MAX + LINK_LAG;
    localparam int ENTRY_W    = $bits(rx_word_t);

    rx_word_t rx_word;
    rx_word_t out_word;
    logic     rx_push;
    logic     fifo_full;
    logic     fifo_empty;

    msg_link_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_sop   (src_sop),
        .src_eop   (src_eop),
        .src_data  (src_data),
        .src_ready (src_ready),
        .fc_in     (lnk_fc_in),
        .tx_data   (lnk_tx_data),
        .tx_en     (lnk_tx_en)
    );

    msg_link_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (lnk_rx_en),
        .rx_data   (lnk_rx_data),
        .push      (rx_push),
        .push_word (rx_word)
    );

    msg_link_fifo #(
        .W          (ENTRY_W),
        .DEPTH      (FIFO_DEPTH),
        .XOFF_LIMIT (XOFF_LIMIT)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push),
        .wr_word (rx_word),
        .rd_en   (dst_ready),
        .rd_word (out_word),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .xoff    (lnk_fc_out)
    );

    assign dst_valid = !fifo_empty;
    assign dst_data  = out_word.data;
    assign dst_first = out_word.first;
    assign dst_last  = out_word.last;
    assign dst_hdr   = out_word.hdr;

endmodule

// File: rtl/msg_link_chk.sv
module msg_link_chk (
    input logic clk,
    input logic rst_n,
    input logic src_valid,
    input logic src_ready,
    input logic src_sop,
    input logic src_eop,
    input logic lnk_tx_en,
    input logic lnk_fc_in,
    input logic dst_valid,
    input logic dst_first,
    input logic dst_hdr,
    input logic rx_push,
    input logic fifo_full
);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !fifo_full);

    assert_idle_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_eop && (src_sop || lnk_tx_en))
        |=> (lnk_tx_en && !src_ready) ##1 !lnk_tx_en);

    assert_no_start_in_xoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_tx_en) |-> $past(!lnk_fc_in, 2));

    assert_first_is_header_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && dst_first) |-> dst_hdr);

endmodule

bind msg_link msg_link_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_sop   (src_sop),
    .src_eop   (src_eop),
    .lnk_tx_en (lnk_tx_en),
    .lnk_fc_in (lnk_fc_in),
    .dst_valid (dst_valid),
    .dst_first (dst_first),
    .dst_hdr   (dst_hdr),
    .rx_push   (rx_push),
    .fifo_full (fifo_full)
);

// File: tb/msg_link_bench.sv
module msg_link_bench;

    logic        clk;
    logic        rst_n;
    logic        src_valid, src_sop, src_eop, src_ready;
    logic [31:0] src_data;
    logic [31:0] lnk_data;
    logic        lnk_en;
    logic        fc_loop;
    logic        force_xoff;
    logic        dst_valid, dst_first, dst_last, dst_hdr, dst_ready;
    logic [31:0] dst_data;

    int n_checks;
    int n_fail;
    bit done;

    logic [31:0] exp_d [0:1023];
    bit          exp_f [0:1023];
    bit          exp_l [0:1023];
    bit          exp_h [0:1023];
    int          wr_i;
    int          rd_i;

    msg_link u_msg_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_valid   (src_valid),
        .src_sop     (src_sop),
        .src_eop     (src_eop),
        .src_data    (src_data),
        .src_ready   (src_ready),
        .lnk_tx_data (lnk_data),
        .lnk_tx_en   (lnk_en),
        .lnk_fc_in   (fc_loop | force_xoff),
        .lnk_rx_data (lnk_data),
        .lnk_rx_en   (lnk_en),
        .lnk_fc_out  (fc_loop),
        .dst_valid   (dst_valid),
        .dst_data    (dst_data),
        .dst_first   (dst_first),
        .dst_last    (dst_last),
        .dst_hdr     (dst_hdr),
        .dst_ready   (dst_ready)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // receive-side scoreboard: R7 order, R8 first/last, R9 header tags
    always @(negedge clk) begin
        if (rst_n && dst_valid && dst_ready) begin
            if (rd_i >= wr_i) begin
                chk(1'b0, "R5/R7 unexpected word", dst_data, 32'h0);
            end else begin
                chk(dst_data == exp_d[rd_i], "R7 data", dst_data, exp_d[rd_i]);
                chk(dst_first == exp_f[rd_i] && dst_last == exp_l[rd_i], "R8 first/last",
                    {30'd0, dst_first, dst_last}, {30'd0, exp_f[rd_i], exp_l[rd_i]});
                chk(dst_hdr == exp_h[rd_i], "R9 header tag", {31'd0, dst_hdr}, {31'd0, exp_h[rd_i]});
            end
            rd_i++;
        end
    end

    task automatic send_msg(input int code, input int plen, input logic [31:0] base);
        int          hl;
        int          total;
        int          i;
        bit          prev_acc;
        logic [31:0] prev_w;
        logic [31:0] w;
        hl       = (code == 0) ? 2 : (code == 1) ? 3 : 4;
        total    = hl + plen;
        i        = 0;
        prev_acc = 1'b0;
        prev_w   = '0;
        while (i < total) begin
            @(posedge clk); #1;
            w         = (i == 0) ? {base[29:0], code[1:0]} : base + i;
            src_valid = 1'b1;
            src_sop   = (i == 0);
            src_eop   = (i == total - 1);
            src_data  = w;
            @(negedge clk);
            if (prev_acc) begin
                chk(lnk_en && lnk_data == prev_w, "R2/R3 link word", lnk_data, prev_w);
            end
            if (i > 0) begin
                chk(src_ready, "R3/R6 message completes", {31'd0, src_ready}, 32'd1);
            end
            if (src_ready) begin
                exp_d[wr_i] = w;
                exp_f[wr_i] = (i == 0);
                exp_l[wr_i] = (i == total - 1);
                exp_h[wr_i] = (i < hl);
                wr_i++;
                prev_acc = 1'b1;
                prev_w   = w;
                i++;
            end else begin
                prev_acc = 1'b0;
            end
        end
        @(posedge clk); #1;
        src_valid = 1'b0;
        src_sop   = 1'b0;
        src_eop   = 1'b0;
        @(negedge clk);
        chk(lnk_en && lnk_data == prev_w, "R2 last link word", lnk_data, prev_w);
        chk(!src_ready, "R4 ready low after end", {31'd0, src_ready}, 32'd0);
        @(negedge clk);
        chk(!lnk_en, "R4 idle cycle", {31'd0, lnk_en}, 32'd0);
    endtask

    task automatic drain();
        int k;
        @(posedge clk); #1;
        dst_ready = 1'b1;
        k = 0;
        while ((dst_valid || lnk_en) && k < 600) begin
            @(negedge clk);
            k++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        n_checks   = 0;
        n_fail     = 0;
        done       = 1'b0;
        wr_i       = 0;
        rd_i       = 0;
        rst_n      = 1'b0;
        src_valid  = 1'b0;
        src_sop    = 1'b0;
        src_eop    = 1'b0;
        src_data   = '0;
        force_xoff = 1'b0;
        dst_ready  = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!lnk_en && !fc_loop, "R1 link idle", {30'd0, lnk_en, fc_loop}, 32'd0);
        chk(!dst_valid, "R1 receive empty", {31'd0, dst_valid}, 32'd0);
        chk(src_ready, "R1 source ready", {31'd0, src_ready}, 32'd1);

        // sweep of header codes and payload sizes (R2, R3, R4, R7, R8, R9)
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                int pl;
                pl = (p == 0) ? 0 : (p == 1) ? 1 : (p == 2) ? 5 : 64;
                send_msg(c, pl, 32'h1000 * (c * 4 + p + 1));
            end
        end
        drain();

        // R5 stray word while idle
        @(posedge clk); #1;
        src_valid = 1'b1;
        src_sop   = 1'b0;
        src_eop   = 1'b0;
        src_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(src_ready, "R5 stray consumed", {31'd0, src_ready}, 32'd1);
        @(posedge clk); #1;
        src_valid = 1'b0;
        @(negedge clk);
        chk(!lnk_en, "R5 stray not sent", {31'd0, lnk_en}, 32'd0);
        repeat (4) @(negedge clk);
        chk(!dst_valid, "R5 stray not received", {31'd0, dst_valid}, 32'd0);

        // R6 XOFF raised in the middle of a message: it still completes
        fork
            send_msg(2, 30, 32'h0002_0000);
            begin
                repeat (6) @(posedge clk);
                #1 force_xoff = 1'b1;
            end
        join
        // R6 no start under XOFF
        repeat (2) @(posedge clk);
        #1;
        src_valid = 1'b1;
        src_sop   = 1'b1;
        src_eop   = 1'b0;
        src_data  = 32'h0003_0000;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!src_ready && !lnk_en, "R6 held off", {30'd0, src_ready, lnk_en}, 32'd0);
        end
        @(posedge clk); #1;
        src_valid  = 1'b0;
        src_sop    = 1'b0;
        force_xoff = 1'b0;
        repeat (2) @(posedge clk);
        send_msg(1, 2, 32'h0004_0000);
        drain();

        // R10 flow-control threshold at 57 and 58 stored words
        @(posedge clk); #1;
        dst_ready = 1'b0;
        send_msg(0, 55, 32'h0005_0000);
        repeat (6) @(negedge clk);
        chk(!fc_loop, "R10 XON at 57 stored", {31'd0, fc_loop}, 32'd0);
        @(posedge clk); #1;
        dst_ready = 1'b1;
        @(posedge clk); #1;
        dst_ready = 1'b0;
        send_msg(0, 0, 32'h0006_0000);
        repeat (6) @(negedge clk);
        chk(fc_loop, "R10 XOFF at 58 stored", {31'd0, fc_loop}, 32'd1);
        fork
            send_msg(1, 3, 32'h0007_0000);
            begin
                for (int k = 0; k < 8; k++) begin
                    @(negedge clk);
                    chk(!lnk_en, "R6 start waits for XON", {31'd0, lnk_en}, 32'd0);
                end
                @(posedge clk); #1;
                dst_ready = 1'b1;
            end
        join
        drain();
        chk(rd_i == wr_i, "R7 all words delivered", rd_i, wr_i);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

endmodule